// File: doc/BRIEF.md
# UART FIFO Ready and Interrupt Logic

This block produces the active-low receive and transmit DMA request lines and the receive-data and transmit-empty interrupt requests for one UART channel. The channel has 16-entry receive and transmit FIFOs. The block does not hold the FIFOs. It watches their fill counts, a receive-timeout flag, the mode controls and the interrupt enables. It also watches single-cycle strobes that mark a receive read, a transmit write and a read of the interrupt status. From these it decides when each line asserts and when it releases.

The channel runs in one of three modes. Single-register mode is used when the FIFOs are disabled. The other two are FIFO mode without DMA and FIFO mode with DMA. The mode changes the rule for each ready line. With DMA enabled, the receive line has hysteresis: it asserts at the trigger level and releases only when the FIFO is empty. The transmit line asserts while there is any free entry. The transmit interrupt fires when the transmit path becomes empty. Software clears it by reading the interrupt status or by loading a character.

Each output is a register that follows the inputs sampled at the previous clock edge.

Top module: `uart_rdy_irq`

## Requirements
- R1: While reset is high, and in the first cycle after it, rx_rdy_n and tx_rdy_n are 1 and rx_irq and tx_irq are 0.
- R2: With fifo_en=0 (single-register mode, dma_mode ignored), rx_rdy_n is 0 exactly when rx_count is nonzero. rx_irq equals ie_rx AND (rx_count nonzero). The receive timeout has no effect.
- R3: With fifo_en=1 and dma_mode=0, rx_rdy_n is 0 while rx_count is at least 1, including below the trigger level. It is 1 when rx_count is 0. In every mode, rx_count=0 gives rx_rdy_n=1.
- R4: With fifo_en=1 and dma_mode=1, rx_rdy_n goes to 0 when rx_count reaches the trigger level or a receive timeout is pending. It then stays 0 as the fill falls below the trigger, and returns to 1 only when rx_count is 0.
- R5: rx_trig_sel selects the receive trigger level: 0 selects 1 entry, 1 selects 4, 2 selects 8 and 3 selects 14.
- R6: With fifo_en=1, rx_irq is 1 when ie_rx=1 and either rx_count is at or above the trigger level or a timeout is pending. Otherwise it is 0.
- R7: A rising edge of rx_timeout sets a pending timeout. An rx_rd pulse clears it, and the clear wins when both happen in the same cycle.
- R8: With fifo_en=0, or with dma_mode=0, tx_rdy_n is 0 exactly when tx_count is 0.
- R9: With fifo_en=1 and dma_mode=1, tx_rdy_n is 0 while tx_count is below 16 and 1 when tx_count is 16.
- R10: tx_irq asserts the cycle after tx_count changes from nonzero to 0, provided ie_tx=1 at that change. If ie_tx=0 at that moment, the event is lost.
- R11: tx_irq is cleared by an isr_rd or tx_wr pulse, which wins over a simultaneous set. It is held at 0 while ie_tx=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register |
| dma_mode | input | 1 | 1 = DMA signalling rules (FIFO mode only) |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | 5 | Receive FIFO fill count, 0 to 16 |
| rx_timeout | input | 1 | Receive data timeout flag |
| tx_count | input | 5 | Transmit FIFO fill count, 0 to 16 |
| ie_rx | input | 1 | Receive-data interrupt enable |
| ie_tx | input | 1 | Transmit-empty interrupt enable |
| rx_rd | input | 1 | One-cycle pulse: receive data read |
| tx_wr | input | 1 | One-cycle pulse: transmit data write |
| isr_rd | input | 1 | One-cycle pulse: interrupt status read |
| rx_rdy_n | output | 1 | Receive ready / DMA request, active low |
| tx_rdy_n | output | 1 | Transmit ready / DMA request, active low |
| rx_irq | output | 1 | Receive-data interrupt request |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
A lost or stuck DMA hysteresis bit shows at rx_rdy_n one cycle after the receive fill drops below the trigger while still nonzero. A pending timeout that is wrong shows at rx_irq one cycle after the flag rises or after a read. A wrong record of the previous transmit fill shows at tx_irq one cycle after the count returns to zero: the interrupt is missing, or it appears with no transition. Because every output is one register away from its inputs, every fault becomes visible at the next clock edge after the stimulus that exposes it.

// File: rtl/uart_ri_pkg.sv
package uart_ri_pkg;

  typedef enum logic [1:0] {
    PM_SINGLE   = 2'd0,
    PM_FIFO     = 2'd1,
    PM_FIFO_DMA = 2'd2
  } path_mode_e;

  function automatic path_mode_e mode_of(input logic fe, input logic dm);
    if (!fe)     return PM_SINGLE;
    else if (dm) return PM_FIFO_DMA;
    else         return PM_FIFO;
  endfunction

endpackage

// File: rtl/uart_rx_sig.sv
module uart_rx_sig
  import uart_ri_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int TRIG_A = 1,
  parameter int TRIG_B = 4,
  parameter int TRIG_C = 8,
  parameter int TRIG_D = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  path_mode_e    mode,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] fill,
  input  logic          timeout,
  input  logic          rd_pulse,
  input  logic          ie,
  output logic          rdy_n,
  output logic          irq
);

  logic [CW-1:0] trig;
  logic          at_trig, nonempty, to_rise, to_next, hold_next;
  logic          rdy_next, irq_next;
  logic          to_prev, to_pend, dma_hold;

  always_comb begin
    case (trig_sel)
      2'd0:    trig = CW'(TRIG_A);
      2'd1:    trig = CW'(TRIG_B);
      2'd2:    trig = CW'(TRIG_C);
      default: trig = CW'(TRIG_D);
    endcase
  end

  always_comb begin
    nonempty  = (fill != '0);
    at_trig   = (fill >= trig);
    to_rise   = timeout & ~to_prev;
    to_next   = ~rd_pulse & (to_pend | to_rise);
    hold_next = nonempty & (dma_hold | at_trig | to_next);
    case (mode)
      PM_FIFO_DMA: rdy_next = hold_next;
      default:     rdy_next = nonempty;
    endcase
    if (mode == PM_SINGLE) irq_next = ie & nonempty;
    else                   irq_next = ie & (at_trig | to_next);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_prev  <= 1'b0;
      to_pend  <= 1'b0;
      dma_hold <= 1'b0;
      rdy_n    <= 1'b1;
      irq      <= 1'b0;
    end else begin
      to_prev  <= timeout;
      to_pend  <= to_next;
      dma_hold <= hold_next;
      rdy_n    <= ~rdy_next;
      irq      <= irq_next;
    end
  end

endmodule

// File: rtl/uart_tx_sig.sv
module uart_tx_sig
  import uart_ri_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  path_mode_e    mode,
  input  logic [CW-1:0] fill,
  input  logic          ie,
  input  logic          wr_pulse,
  input  logic          stat_rd,
  output logic          rdy_n,
  output logic          irq
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic was_nz, empty_edge, rdy_next, irq_next;

  always_comb begin
    empty_edge = (fill == '0) & was_nz;
    irq_next   = ie & ~(wr_pulse | stat_rd) & (irq | empty_edge);
    case (mode)
      PM_FIFO_DMA: rdy_next = (fill < FULL);
      default:     rdy_next = (fill == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      was_nz <= 1'b0;
      rdy_n  <= 1'b1;
      irq    <= 1'b0;
    end else begin
      was_nz <= (fill != '0);
      rdy_n  <= ~rdy_next;
      irq    <= irq_next;
    end
  end

endmodule

// File: rtl/uart_rdy_irq.sv
module uart_rdy_irq
  import uart_ri_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [1:0]    rx_trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  input  logic [CW-1:0] tx_count,
  input  logic          ie_rx,
  input  logic          ie_tx,
  input  logic          rx_rd,
  input  logic          tx_wr,
  input  logic          isr_rd,
  output logic          rx_rdy_n,
  output logic          tx_rdy_n,
  output logic          rx_irq,
  output logic          tx_irq
);

  path_mode_e mode;
  assign mode = mode_of(fifo_en, dma_mode);

  uart_rx_sig #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .trig_sel (rx_trig_sel),
    .fill     (rx_count),
    .timeout  (rx_timeout),
    .rd_pulse (rx_rd),
    .ie       (ie_rx),
    .rdy_n    (rx_rdy_n),
    .irq      (rx_irq)
  );

  uart_tx_sig #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .fill     (tx_count),
    .ie       (ie_tx),
    .wr_pulse (tx_wr),
    .stat_rd  (isr_rd),
    .rdy_n    (tx_rdy_n),
    .irq      (tx_irq)
  );

endmodule

// File: rtl/uart_rdy_irq_chk.sv
module uart_rdy_irq_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          dma_mode,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          ie_rx,
  input logic          ie_tx,
  input logic          tx_wr,
  input logic          isr_rd,
  input logic          rx_rdy_n,
  input logic          tx_rdy_n,
  input logic          rx_irq,
  input logic          tx_irq
);

  AST_RXRDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && rx_count != '0) |=> !rx_rdy_n); // R2

  AST_RXRDY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |=> rx_rdy_n); // R3

  AST_RXIRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !ie_rx |=> !rx_irq); // R6

  AST_RXIRQ_TOP: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && ie_rx && rx_count >= CW'(14)) |=> rx_irq); // R6

  AST_TXRDY_NODMA: assert property (@(posedge clk) disable iff (rst)
    ((!fifo_en || !dma_mode) && tx_count != '0) |=> tx_rdy_n); // R8

  AST_TXRDY_FULL: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_mode && tx_count == CW'(DEPTH)) |=> tx_rdy_n); // R9

  AST_TXIRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (isr_rd || tx_wr) |=> !tx_irq); // R11

  AST_TXIRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    !ie_tx |=> !tx_irq); // R11

endmodule

bind uart_rdy_irq uart_rdy_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fifo_en  (fifo_en),
  .dma_mode (dma_mode),
  .rx_count (rx_count),
  .tx_count (tx_count),
  .ie_rx    (ie_rx),
  .ie_tx    (ie_tx),
  .tx_wr    (tx_wr),
  .isr_rd   (isr_rd),
  .rx_rdy_n (rx_rdy_n),
  .tx_rdy_n (tx_rdy_n),
  .rx_irq   (rx_irq),
  .tx_irq   (tx_irq)
);

// File: tb/tb_uart_rdy_irq.sv
`timescale 1ns/1ps
module tb_uart_rdy_irq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0, dma_mode = 1'b0;
  logic [1:0] rx_trig_sel = 2'd0;
  logic [4:0] rx_count = '0, tx_count = '0;
  logic       rx_timeout = 1'b0, ie_rx = 1'b0, ie_tx = 1'b0;
  logic       rx_rd = 1'b0, tx_wr = 1'b0, isr_rd = 1'b0;
  logic       rx_rdy_n, tx_rdy_n, rx_irq, tx_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  uart_rdy_irq dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .rx_trig_sel(rx_trig_sel), .rx_count(rx_count), .rx_timeout(rx_timeout),
    .tx_count(tx_count), .ie_rx(ie_rx), .ie_tx(ie_tx), .rx_rd(rx_rd),
    .tx_wr(tx_wr), .isr_rd(isr_rd), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check("R1", "rx_rdy_n in reset", rx_rdy_n, 1'b1);
    check("R1", "tx_rdy_n in reset", tx_rdy_n, 1'b1);
    check("R1", "rx_irq in reset", rx_irq, 1'b0);
    check("R1", "tx_irq in reset", tx_irq, 1'b0);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_single();
    fifo_en = 1'b0; dma_mode = 1'b1; ie_rx = 1'b1; rx_trig_sel = 2'd3;
    rx_count = 5'd1; tick();
    check("R2", "rx_rdy_n byte held", rx_rdy_n, 1'b0);
    check("R2", "rx_irq byte held", rx_irq, 1'b1);
    rx_count = 5'd0; rx_rd = 1'b1; tick(); rx_rd = 1'b0;
    check("R2", "rx_rdy_n after read", rx_rdy_n, 1'b1);
    check("R2", "rx_irq after read", rx_irq, 1'b0);
    rx_timeout = 1'b1; tick();
    check("R2", "timeout ignored irq", rx_irq, 1'b0);
    check("R2", "timeout ignored rdy", rx_rdy_n, 1'b1);
    rx_timeout = 1'b0; rx_rd = 1'b1; tick(); rx_rd = 1'b0;
    tx_count = 5'd0; tick();
    check("R8", "tx_rdy_n single empty", tx_rdy_n, 1'b0);
    tx_count = 5'd1; tick();
    check("R8", "tx_rdy_n single loaded", tx_rdy_n, 1'b1);
    tx_count = 5'd0; tick();
  endtask

  task automatic t_fifo_plain();
    fifo_en = 1'b1; dma_mode = 1'b0; ie_rx = 1'b1; rx_trig_sel = 2'd2;
    rx_count = 5'd1; tick();
    check("R3", "rx_rdy_n first byte", rx_rdy_n, 1'b0);
    check("R6", "rx_irq below trigger", rx_irq, 1'b0);
    rx_count = 5'd8; tick();
    check("R6", "rx_irq at trigger 8", rx_irq, 1'b1);
    rx_count = 5'd3; tick();
    check("R6", "rx_irq drops below trigger", rx_irq, 1'b0);
    check("R3", "rx_rdy_n still low", rx_rdy_n, 1'b0);
    rx_count = 5'd0; tick();
    check("R3", "rx_rdy_n empty", rx_rdy_n, 1'b1);
    tx_count = 5'd3; tick();
    check("R8", "tx_rdy_n fifo has data", tx_rdy_n, 1'b1);
    tx_count = 5'd0; tick();
    check("R8", "tx_rdy_n fifo empty", tx_rdy_n, 1'b0);
  endtask

  task automatic t_dma_rx();
    fifo_en = 1'b1; dma_mode = 1'b1; rx_trig_sel = 2'd1;
    rx_count = 5'd3; tick();
    check("R4", "rx_rdy_n below trigger", rx_rdy_n, 1'b1);
    rx_count = 5'd4; tick();
    check("R4", "rx_rdy_n at trigger", rx_rdy_n, 1'b0);
    rx_count = 5'd2; tick();
    check("R4", "rx_rdy_n held below trigger", rx_rdy_n, 1'b0);
    rx_count = 5'd0; tick();
    check("R4", "rx_rdy_n released on empty", rx_rdy_n, 1'b1);
  endtask

  task automatic t_trig();
    int lv[4] = '{1, 4, 8, 14};
    fifo_en = 1'b1; dma_mode = 1'b0; ie_rx = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rx_trig_sel = 2'(s);
      rx_count = 5'(lv[s] - 1); tick();
      check("R5", $sformatf("sel %0d one below", s), rx_irq, 1'b0);
      rx_count = 5'(lv[s]); tick();
      check("R5", $sformatf("sel %0d at level", s), rx_irq, 1'b1);
    end
    rx_count = 5'd0; tick();
  endtask

  task automatic t_timeout();
    fifo_en = 1'b1; dma_mode = 1'b1; rx_trig_sel = 2'd3; ie_rx = 1'b1;
    rx_count = 5'd2; tick();
    check("R4", "rx_rdy_n no trigger yet", rx_rdy_n, 1'b1);
    rx_timeout = 1'b1; tick();
    check("R7", "rx_irq on timeout", rx_irq, 1'b1);
    check("R4", "rx_rdy_n on timeout", rx_rdy_n, 1'b0);
    tick();
    check("R7", "timeout stays pending", rx_irq, 1'b1);
    rx_rd = 1'b1; tick(); rx_rd = 1'b0; rx_timeout = 1'b0;
    check("R7", "read clears timeout", rx_irq, 1'b0);
    tick();
    check("R4", "rx_rdy_n held after timeout", rx_rdy_n, 1'b0);
    rx_timeout = 1'b1; rx_rd = 1'b1; tick(); rx_rd = 1'b0; rx_timeout = 1'b0;
    check("R7", "read wins over new timeout", rx_irq, 1'b0);
    rx_count = 5'd0; tick();
    check("R4", "rx_rdy_n empty after timeout", rx_rdy_n, 1'b1);
  endtask

  task automatic t_tx_dma();
    fifo_en = 1'b1; dma_mode = 1'b1;
    tx_count = 5'd15; tick();
    check("R9", "tx_rdy_n one free", tx_rdy_n, 1'b0);
    tx_count = 5'd16; tick();
    check("R9", "tx_rdy_n full", tx_rdy_n, 1'b1);
    tx_count = 5'd15; tick();
    check("R9", "tx_rdy_n space again", tx_rdy_n, 1'b0);
    tx_count = 5'd0; tick();
  endtask

  task automatic t_tx_irq();
    fifo_en = 1'b1; dma_mode = 1'b0; ie_tx = 1'b1;
    tx_count = 5'd2; tick();
    check("R10", "tx_irq while data", tx_irq, 1'b0);
    tx_count = 5'd0; tick();
    check("R10", "tx_irq on empty", tx_irq, 1'b1);
    tick();
    check("R10", "tx_irq stays", tx_irq, 1'b1);
    isr_rd = 1'b1; tick(); isr_rd = 1'b0;
    check("R11", "isr read clears", tx_irq, 1'b0);
    tick();
    check("R11", "no re-set without edge", tx_irq, 1'b0);
    tx_count = 5'd1; tick(); tx_count = 5'd0; tick();
    check("R10", "tx_irq second empty", tx_irq, 1'b1);
    tx_wr = 1'b1; tick(); tx_wr = 1'b0;
    check("R11", "write clears", tx_irq, 1'b0);
    tx_count = 5'd1; tick(); tx_count = 5'd0; isr_rd = 1'b1; tick(); isr_rd = 1'b0;
    check("R11", "clear wins over set", tx_irq, 1'b0);
    tx_count = 5'd1; tick(); tx_count = 5'd0; tick();
    check("R10", "tx_irq third empty", tx_irq, 1'b1);
    ie_tx = 1'b0; tick();
    check("R11", "enable off masks", tx_irq, 1'b0);
    tx_count = 5'd1; tick(); tx_count = 5'd0; tick();
    check("R10", "no set while disabled", tx_irq, 1'b0);
    ie_tx = 1'b1; tick();
    check("R10", "lost event stays lost", tx_irq, 1'b0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset();
    t_single();
    t_fifo_plain();
    t_dma_rx();
    t_trig();
    t_timeout();
    t_tx_dma();
    t_tx_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule